// File: doc/BRIEF.md
# Phase-Offset Programmable Clock Divider

This block divides a fast input clock by a programmable ratio and lets the first edge of the divided clock fall a chosen number of fast-clock cycles after a synchronization pulse. The high time and the low time of the divided clock are set separately, so the ratio and the duty cycle are both programmable. A five-bit delay selects the phase. Its lower four bits are an offset, and its top bit is a start-level bit that also adds sixteen cycles to the wait.

Several copies that share one sync pulse and one fast clock keep fixed skews between their outputs. Each skew is a whole number of fast-clock periods. The configuration is captured on the sync pulse, so software may change the inputs between pulses without disturbing a running output.

Top module: `phase_clk_div`

## Requirements
- R1: While reset is high, and after reset until the first sync pulse, `clk_o` is low.
- R2: At the clock edge that samples `sync_i` high, `clk_o` takes the inverse of `start_hi_i`. It stays at that level for the whole offset wait.
- R3: Let the delay D be the value {`start_hi_i`, `phase_i`} (0 to 31). If sync is sampled at edge E0, `clk_o` first moves to the start level at edge E0+D+1.
- R4: A high-count field value n gives n+1 high cycles, and a low-count field value m gives m+1 low cycles. The divide ratio is n+m+2, and the levels alternate without a gap.
- R5: With `start_hi_i` = 1, the output begins high and the wait is 16 cycles longer than the same `phase_i` with `start_hi_i` = 0.
- R6: A sync pulse that arrives during the wait or during a period stops it at once, and the R2/R3 sequence starts again from that edge.
- R7: Changes to the configuration inputs while `sync_i` is low have no effect on `clk_o` until the next sync pulse.
- R8: At a divide ratio of 4, offsets 0 and 4 give the same steady-state phase. Offsets 0 to 3 give quarter-period steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | One-cycle synchronization pulse |
| hi_cnt_i | input | 4 | High time minus one, in fast-clock cycles |
| lo_cnt_i | input | 4 | Low time minus one, in fast-clock cycles |
| phase_i | input | 4 | Phase offset in fast-clock cycles |
| start_hi_i | input | 1 | Start level; also adds 16 cycles to the wait |
| clk_o | output | 1 | Registered divided clock |

## Verification
Every result is tied to the edge E0 that samples the sync pulse. The inverted start level appears after E0. The first start-level edge follows E0 by D+1 edges, and each later toggle follows the one before it by the high or low count plus one. The driver pushes one expected `clk_o` value per cycle, starting with the cycle after E0, as soon as it releases the pulse. The monitor pops one value at each falling edge, so each expectation is checked at the cycle it describes.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int CNT_W_DEF = 4;
  localparam int PH_W_DEF  = 4;
endpackage

// File: rtl/pcd_cfg_reg.sv
module pcd_cfg_reg #(
  parameter int CNT_W = pcd_pkg::CNT_W_DEF,
  parameter int PH_W  = pcd_pkg::PH_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  input  logic [PH_W-1:0]  ph_in,
  input  logic             st_in,
  output logic [CNT_W-1:0] hi_q,
  output logic [CNT_W-1:0] lo_q,
  output logic [PH_W-1:0]  ph_q,
  output logic             st_q
);
  // capture the settings only when a sync pulse arrives
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
      ph_q <= '0;
      st_q <= 1'b0;
    end else if (sync) begin
      hi_q <= hi_in;
      lo_q <= lo_in;
      ph_q <= ph_in;
      st_q <= st_in;
    end
  end
endmodule

// File: rtl/pcd_offset_wait.sv
module pcd_offset_wait #(
  parameter int DLY_W = pcd_pkg::PH_W_DEF + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic [DLY_W-1:0] dly,
  output logic             go
);
  logic             busy;
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (sync) begin
      busy <= 1'b1;
      cnt  <= dly;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // last waiting cycle; a new sync takes precedence
  assign go = busy && (cnt == '0) && !sync;
endmodule

// File: rtl/pcd_level_gen.sv
module pcd_level_gen #(
  parameter int CNT_W = pcd_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic             st_now,
  input  logic             go,
  input  logic             st_q,
  input  logic [CNT_W-1:0] hi_q,
  input  logic [CNT_W-1:0] lo_q,
  output logic             out
);
  logic             run;
  logic [CNT_W-1:0] lcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      out  <= 1'b0;
      run  <= 1'b0;
      lcnt <= '0;
    end else if (sync) begin
      out  <= ~st_now;
      run  <= 1'b0;
      lcnt <= '0;
    end else if (go) begin
      out  <= st_q;
      run  <= 1'b1;
      lcnt <= st_q ? hi_q : lo_q;
    end else if (run) begin
      if (lcnt == '0) begin
        out  <= ~out;
        lcnt <= out ? lo_q : hi_q;
      end else begin
        lcnt <= lcnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/phase_clk_div.sv
module phase_clk_div #(
  parameter int CNT_W = pcd_pkg::CNT_W_DEF,
  parameter int PH_W  = pcd_pkg::PH_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] hi_cnt_i,
  input  logic [CNT_W-1:0] lo_cnt_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             start_hi_i,
  output logic             clk_o
);
  localparam int DLY_W = PH_W + 1;

  logic [CNT_W-1:0] hi_q, lo_q;
  logic [PH_W-1:0]  ph_q;
  logic             st_q;
  logic             go;
  logic [DLY_W-1:0] dly;

  // the start bit is the top bit of the wait length
  assign dly = {start_hi_i, phase_i};

  pcd_cfg_reg #(.CNT_W(CNT_W), .PH_W(PH_W)) u_cfg (
    .clk(clk), .rst(rst), .sync(sync_i),
    .hi_in(hi_cnt_i), .lo_in(lo_cnt_i), .ph_in(phase_i), .st_in(start_hi_i),
    .hi_q(hi_q), .lo_q(lo_q), .ph_q(ph_q), .st_q(st_q)
  );

  pcd_offset_wait #(.DLY_W(DLY_W)) u_wait (
    .clk(clk), .rst(rst), .sync(sync_i), .dly(dly), .go(go)
  );

  pcd_level_gen #(.CNT_W(CNT_W)) u_lvl (
    .clk(clk), .rst(rst), .sync(sync_i), .st_now(start_hi_i), .go(go),
    .st_q(st_q), .hi_q(hi_q), .lo_q(lo_q), .out(clk_o)
  );
endmodule

// File: rtl/phase_clk_div_chk.sv
module phase_clk_div_chk #(
  parameter int CNT_W = pcd_pkg::CNT_W_DEF,
  parameter int PH_W  = pcd_pkg::PH_W_DEF
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      sync_i,
  input logic                      start_hi_i,
  input logic                      clk_o,
  input logic                      go,
  input logic [2*CNT_W+PH_W:0]     cfg_bits
);
  localparam int HOLD_MAX = 2 ** (PH_W + 1) + 2 ** CNT_W + 2;

  logic        seen;
  logic        prev_o;
  int unsigned hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen   <= 1'b0;
      prev_o <= 1'b0;
      hold   <= 0;
    end else begin
      prev_o <= clk_o;
      if (sync_i) seen <= 1'b1;
      if (sync_i || clk_o != prev_o) hold <= 0;
      else                           hold <= hold + 1;
    end
  end

  p_reset_low_r1: assert property (@(posedge clk) rst |=> !clk_o);

  p_sync_level_r2: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> (clk_o == !$past(start_hi_i)));

  p_first_edge_r3: assert property (@(posedge clk) disable iff (rst)
    go |=> (clk_o == cfg_bits[0]));

  p_cfg_held_r7: assert property (@(posedge clk) disable iff (rst)
    !sync_i |=> $stable(cfg_bits));

  p_bounded_hold_r4: assert property (@(posedge clk) disable iff (rst)
    seen |-> (hold <= HOLD_MAX));
endmodule

bind phase_clk_div phase_clk_div_chk #(.CNT_W(CNT_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst(rst), .sync_i(sync_i), .start_hi_i(start_hi_i),
  .clk_o(clk_o), .go(go), .cfg_bits({hi_q, lo_q, ph_q, st_q})
);

// File: tb/phase_clk_div_bench.sv
module phase_clk_div_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_i = 1'b0;
  logic [3:0] hi_cnt_i = '0, lo_cnt_i = '0, phase_i = '0;
  logic       start_hi_i = 1'b0;
  logic       clk_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  phase_clk_div u_phase_clk_div (
    .clk(clk), .rst(rst), .sync_i(sync_i), .hi_cnt_i(hi_cnt_i),
    .lo_cnt_i(lo_cnt_i), .phase_i(phase_i), .start_hi_i(start_hi_i),
    .clk_o(clk_o)
  );

  // monitor: one expectation per cycle, sampled at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (clk_o !== e) begin
        fails++;
        $display("FAIL %s: clk_o actual %b expected %b at %0t", t, clk_o, e, $time);
      end
    end
  end

  // expected waveform from the requirements: D+1 cycles at the inverted
  // start level, then start level for its count+1, then alternate
  task automatic push_exp(input int hi, input int lo, input int ph,
                          input bit st, input int len, input string tag);
    int d, per, first;
    d     = (st ? 16 : 0) + ph;
    per   = hi + lo + 2;
    first = st ? hi + 1 : lo + 1;
    for (int i = 0; i < len; i++) begin
      if (i <= d) exp_q.push_back(~st);
      else        exp_q.push_back((((i - d - 1) % per) < first) ? st : ~st);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic run_sync(input int hi, input int lo, input int ph,
                          input bit st, input int len, input bit scramble,
                          input string tag);
    @(posedge clk); #1;
    sync_i = 1'b1; hi_cnt_i = hi[3:0]; lo_cnt_i = lo[3:0];
    phase_i = ph[3:0]; start_hi_i = st;
    @(posedge clk); #1;
    sync_i = 1'b0;
    if (scramble) begin
      hi_cnt_i = ~hi_cnt_i; lo_cnt_i = ~lo_cnt_i;
      phase_i = ~phase_i; start_hi_i = ~start_hi_i;
    end
    push_exp(hi, lo, ph, st, len, tag);
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: low during reset and idle until the first sync
    exp_q.push_back(1'b0); tag_q.push_back("R1");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(1'b0); tag_q.push_back("R1");
    end
    phase_i = 4'd2; hi_cnt_i = 4'd3;
    drain();

    // R2 R3 R4: divide by 4, offset 0
    run_sync(1, 1, 0, 1'b0, 14, 1'b0, "R2_R3_R4_div4_ph0");
    // R3 R8: offset 3 gives the 270 degree position
    run_sync(1, 1, 3, 1'b0, 16, 1'b0, "R3_R8_ph3");
    // R8: offset 4 lines up with offset 0 at divide by 4
    run_sync(1, 1, 4, 1'b0, 17, 1'b0, "R8_ph4");
    // R5 R4: start high, uneven duty 3 high, 5 low
    run_sync(2, 4, 2, 1'b1, 40, 1'b0, "R5_R4_start_hi");
    // R3 R5: maximum wait of 31, minimum ratio of 2
    run_sync(0, 0, 15, 1'b1, 40, 1'b0, "R3_R5_max_delay");
    // R4: maximum ratio of 32
    run_sync(15, 15, 1, 1'b0, 70, 1'b0, "R4_max_ratio");
    // R6: sync during the wait, then sync during a period
    run_sync(1, 2, 10, 1'b0, 5, 1'b0, "R6_abort_wait");
    run_sync(2, 1, 1, 1'b0, 7, 1'b0, "R6_abort_run");
    run_sync(1, 3, 0, 1'b1, 30, 1'b0, "R6_restart");
    // R7: inputs change after the pulse; output follows captured values
    run_sync(2, 5, 3, 1'b0, 30, 1'b1, "R7_cfg_held");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule